// File: doc/BRIEF.md
# FIFO-Fed Printer Strobe Engine

This block feeds a one-way byte-wide printer port from a small on-chip byte queue. A DMA-style mover fills the queue. For each byte the engine drives the byte onto the data pins, waits a setup interval, pulses the active-low strobe, and then keeps the byte steady for a hold interval. The three intervals are set by count inputs in system clock cycles. With a 100 MHz clock, counts near 60/80/55 give a byte period of about 2 us, which matches the target of roughly 500 kilobytes per second.

Pacing between bytes depends only on the peripheral's busy line. Busy passes through a flop synchronizer, and a new byte starts only when the synchronized busy is low. The block has no acknowledge input, so a byte never waits on an acknowledge pulse. The engine runs only while the 3-bit mode input holds the queue-driven mode code 3'b101.

Top module: `lpt_fifo_strober`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `strobe_n` is 1, `pd_out` is 8'h00 and the queue is empty.
- R2: When `mode_sel` differs from 3'b101, no new byte is launched and `dma_req` is 0. Queued bytes wait until the mode returns to 3'b101.
- R3: `dma_req` is 1 exactly when `mode_sel` is 3'b101 and the queue holds fewer than DEPTH bytes.
- R4: A byte on `dma_data` is written when `dma_ack` is 1 and the queue is not full. A write offered while the queue is full is dropped and never reaches `pd_out`.
- R5: Bytes appear on `pd_out` in the order they were written, one per transfer.
- R6: `strobe_n` falls `setup_len`+1 cycles after `pd_out` takes a new byte and stays low for `pulse_len`+1 cycles.
- R7: After `strobe_n` rises, `pd_out` stays unchanged for at least `hold_len`+2 cycles. When bytes are waiting and busy is low, the next byte appears exactly `hold_len`+2 cycles after the rise.
- R8: A byte is launched only in a cycle where `busy_in`, delayed by the two-flop synchronizer, is low. While busy stays high, `strobe_n` stays 1.
- R9: Busy is examined only between transfers. Busy rising during a transfer neither shortens nor stretches that transfer's strobe.
- R10: When the queue is empty, `strobe_n` stays 1 and `pd_out` keeps the last byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Port mode; the engine runs at 3'b101 |
| dma_ack | input | 1 | Write strobe from the DMA mover |
| dma_data | input | 8 | Byte written with `dma_ack` |
| dma_req | output | 1 | Request for more bytes |
| setup_len | input | CNT_W | Setup interval count |
| pulse_len | input | CNT_W | Strobe low interval count |
| hold_len | input | CNT_W | Hold interval count |
| busy_in | input | 1 | Asynchronous peripheral busy line |
| pd_out | output | 8 | Parallel data pins |
| strobe_n | output | 1 | Active-low data strobe |

## Verification
The bench builds the engine with DEPTH=4, CNT_W=8 and a two-stage synchronizer. The shallow queue lets six back-to-back writes reach the full condition within a few cycles, which exercises both the request drop and the discarding of surplus bytes. The 8-bit counts reach from the all-zero case (four-cycle byte period) to counts of 60/80/55 that give the roughly 2 us period. Busy is raised during a long strobe to show that it has no effect mid-transfer.

// File: rtl/lpt_fifo_pkg.sv
package lpt_fifo_pkg;

    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_FIFO_COMPAT = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_e;

    function automatic logic mode_enabled(input logic [MODE_W-1:0] m);
        return m == MODE_FIFO_COMPAT;
    endfunction

endpackage

// File: rtl/lpt_sync_chain.sv
module lpt_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sr[STAGES-1];
endmodule

// File: rtl/lpt_byte_fifo.sv
module lpt_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          wr_ok, rd_ok;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= bump(wr_ptr);
            if (rd_ok) rd_ptr <= bump(rd_ptr);
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/lpt_strobe_seq.sv
module lpt_strobe_seq
    import lpt_fifo_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    fifo_data,
    input  logic             busy_sync,
    input  logic [CNT_W-1:0] setup_len,
    input  logic [CNT_W-1:0] pulse_len,
    input  logic [CNT_W-1:0] hold_len,
    output logic             pop,
    output logic [DW-1:0]    pd_out,
    output logic             strobe_n
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             cnt_done;

    assign cnt_done = (cnt == '0);
    assign pop      = (state == ST_IDLE) && run_en && !fifo_empty && !busy_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            pd_out   <= '0;
            strobe_n <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pop) begin
                        pd_out <= fifo_data;
                        cnt    <= setup_len;
                        state  <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (cnt_done) begin
                        strobe_n <= 1'b0;
                        cnt      <= pulse_len;
                        state    <= ST_STROBE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt_done) begin
                        strobe_n <= 1'b1;
                        cnt      <= hold_len;
                        state    <= ST_HOLD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_done) state <= ST_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpt_fifo_strober.sv
module lpt_fifo_strober
    import lpt_fifo_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [MODE_W-1:0]   mode_sel,
    input  logic                dma_ack,
    input  logic [BYTE_W-1:0]   dma_data,
    output logic                dma_req,
    input  logic [CNT_W-1:0]    setup_len,
    input  logic [CNT_W-1:0]    pulse_len,
    input  logic [CNT_W-1:0]    hold_len,
    input  logic                busy_in,
    output logic [BYTE_W-1:0]   pd_out,
    output logic                strobe_n
);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              run_en;
    logic              busy_sync;
    logic              pop;
    logic              fifo_full, fifo_empty;
    logic [BYTE_W-1:0] fifo_head;
    logic [LVL_W-1:0]  fifo_level;

    assign run_en  = mode_enabled(mode_sel);
    assign dma_req = run_en && !fifo_full;

    lpt_sync_chain #(.STAGES(SYNC_STAGES)) u_busy_sync (
        .clk (clk),
        .rst (rst),
        .d   (busy_in),
        .q   (busy_sync)
    );

    lpt_byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dma_ack),
        .wr_data (dma_data),
        .rd_en   (pop),
        .rd_data (fifo_head),
        .level   (fifo_level),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    lpt_strobe_seq #(.DW(BYTE_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_head),
        .busy_sync  (busy_sync),
        .setup_len  (setup_len),
        .pulse_len  (pulse_len),
        .hold_len   (hold_len),
        .pop        (pop),
        .pd_out     (pd_out),
        .strobe_n   (strobe_n)
    );
endmodule

// File: rtl/lpt_fifo_strober_chk.sv
module lpt_fifo_strober_chk #(
    parameter int DEPTH = 16,
    parameter int LW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    mode_sel,
    input logic          dma_ack,
    input logic          dma_req,
    input logic          busy_sync,
    input logic          pop,
    input logic [LW-1:0] fifo_level,
    input logic [7:0]    pd_out,
    input logic          strobe_n
);
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    assert_no_req_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LW'(DEPTH)) |-> !dma_req);

    assert_reject_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        (fifo_level == LW'(DEPTH) && dma_ack && !pop) |=> $stable(fifo_level));

    assert_launch_guard_R8: assert property (@(posedge clk) disable iff (rst)
        pop |-> (!busy_sync && mode_sel == 3'b101));

    assert_launch_nonempty_R10: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fifo_level != '0));

    assert_data_steady_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> $stable(pd_out));
endmodule

bind lpt_fifo_strober lpt_fifo_strober_chk #(.DEPTH(DEPTH), .LW(LVL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_sel   (mode_sel),
    .dma_ack    (dma_ack),
    .dma_req    (dma_req),
    .busy_sync  (busy_sync),
    .pop        (pop),
    .fifo_level (fifo_level),
    .pd_out     (pd_out),
    .strobe_n   (strobe_n)
);

// File: tb/lpt_fifo_strober_bench.sv
module lpt_fifo_strober_bench;
    localparam int DEPTH = 4;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       mode_sel = 3'b000;
    logic             dma_ack = 1'b0;
    logic [7:0]       dma_data = 8'h00;
    logic             dma_req;
    logic [CNT_W-1:0] setup_len = 8'd2;
    logic [CNT_W-1:0] pulse_len = 8'd3;
    logic [CNT_W-1:0] hold_len  = 8'd1;
    logic             busy_in = 1'b0;
    logic [7:0]       pd_out;
    logic             strobe_n;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lpt_fifo_strober #(.DEPTH(DEPTH), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_lpt_fifo_strober (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .dma_ack(dma_ack),
        .dma_data(dma_data), .dma_req(dma_req), .setup_len(setup_len),
        .pulse_len(pulse_len), .hold_len(hold_len), .busy_in(busy_in),
        .pd_out(pd_out), .strobe_n(strobe_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: queue of pending bytes and a timer since launch.
    logic [7:0] q[$];
    bit         m_busy_xfer = 0;
    int         m_el = 0;
    logic [7:0] m_pd = 8'h00;
    bit         m_s1 = 0, m_s2 = 0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_busy_xfer = 0; m_el = 0; m_pd = 8'h00; m_s1 = 0; m_s2 = 0;
        end else begin
            int  sz;
            bit  launch;
            sz = q.size();
            launch = !m_busy_xfer && mode_sel == 3'b101 && sz > 0 && !m_s2;
            if (m_busy_xfer) begin
                m_el++;
                if (m_el == int'(setup_len) + int'(pulse_len) + int'(hold_len) + 3)
                    m_busy_xfer = 0;
            end
            if (launch) begin
                m_pd = q.pop_front();
                m_busy_xfer = 1;
                m_el = 0;
            end
            if (dma_ack && sz < DEPTH) q.push_back(dma_data);
            m_s2 = m_s1;
            m_s1 = busy_in;
        end
    end

    // Per-clock comparison and observation of the pins.
    logic [7:0] got[$];
    int  cyc = 0;
    int  last_change = -1, last_fall = -1, last_rise = -1;
    int  setup_gap = -1, low_len = -1, hold_gap = -1, low_run = 0;
    logic [7:0] prev_pd = 8'h00;
    bit  prev_sn = 1;

    always @(posedge clk) begin
        #2;
        cyc++;
        begin
            bit exp_sn;
            bit exp_req;
            exp_sn  = !(m_busy_xfer && m_el >= int'(setup_len) + 1 &&
                        m_el <= int'(setup_len) + int'(pulse_len) + 1);
            exp_req = (mode_sel == 3'b101) && (q.size() < DEPTH);
            chk(pd_out == m_pd, "R5 pd_out vs model", pd_out, m_pd);
            chk(strobe_n == exp_sn, "R6 strobe_n vs model", strobe_n, exp_sn);
            chk(dma_req == exp_req, "R3 dma_req vs model", dma_req, exp_req);
        end
        if (pd_out != prev_pd) begin
            last_change = cyc;
            if (last_rise >= 0) hold_gap = cyc - last_rise;
        end
        if (prev_sn && !strobe_n) begin
            last_fall = cyc;
            setup_gap = cyc - last_change;
            got.push_back(pd_out);
            low_run = 0;
        end
        if (!strobe_n) low_run++;
        if (!prev_sn && strobe_n) begin
            last_rise = cyc;
            low_len = low_run;
        end
        prev_pd = pd_out;
        prev_sn = strobe_n;
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        dma_ack = 1'b1;
        dma_data = b;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && !m_busy_xfer && strobe_n) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(strobe_n == 1'b1, "R1 strobe_n in reset", strobe_n, 1);
        chk(pd_out == 8'h00, "R1 pd_out in reset", pd_out, 0);
        chk(dma_req == 1'b0, "R1 dma_req in reset", dma_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(strobe_n == 1'b1 && pd_out == 8'h00, "R1 after release", pd_out, 0);

        // R2: wrong mode blocks launch and request
        mode_sel = 3'b001;
        push(8'h11);
        push(8'h22);
        repeat (30) @(negedge clk);
        chk(got.size() == 0, "R2 no launch in other mode", got.size(), 0);
        chk(dma_req == 1'b0, "R2 dma_req low in other mode", dma_req, 0);
        chk(strobe_n == 1'b1, "R2 strobe idle in other mode", strobe_n, 1);
        mode_sel = 3'b101;
        wait_idle();
        chk(got.size() == 2, "R5 two bytes sent", got.size(), 2);
        if (got.size() == 2) begin
            chk(got[0] == 8'h11, "R5 first byte", got[0], 8'h11);
            chk(got[1] == 8'h22, "R5 second byte", got[1], 8'h22);
        end
        chk(setup_gap == 3, "R6 setup gap", setup_gap, 3);
        chk(low_len == 4, "R6 pulse width", low_len, 4);
        chk(hold_gap == 3, "R7 hold to next byte", hold_gap, 3);

        // R3, R4, R8: fill while busy, overflow, then release
        got.delete();
        busy_in = 1'b1;
        repeat (4) @(negedge clk);
        push(8'hA1);
        push(8'hA2);
        push(8'hA3);
        chk(dma_req == 1'b1, "R3 request with one slot free", dma_req, 1);
        push(8'hA4);
        chk(dma_req == 1'b0, "R3 request dropped when full", dma_req, 0);
        push(8'hE5);
        push(8'hE6);
        repeat (40) @(negedge clk);
        chk(got.size() == 0, "R8 no launch while busy", got.size(), 0);
        chk(strobe_n == 1'b1, "R8 strobe idle while busy", strobe_n, 1);
        busy_in = 1'b0;
        wait_idle();
        chk(got.size() == 4, "R4 only queued bytes sent", got.size(), 4);
        for (int i = 0; i < 4 && i < got.size(); i++)
            chk(got[i] == 8'hA1 + 8'(i), "R4 R5 byte order after overflow", got[i], 8'hA1 + i);

        // R9: busy rising mid-pulse has no effect on the pulse
        setup_len = 8'd1; pulse_len = 8'd20; hold_len = 8'd2;
        push(8'h5C);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!strobe_n) break;
        end
        busy_in = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (strobe_n) break;
        end
        repeat (2) @(negedge clk);
        chk(low_len == 21, "R9 pulse unaffected by busy", low_len, 21);
        busy_in = 1'b0;
        wait_idle();

        // R10: empty queue holds last byte, strobe idle
        repeat (20) @(negedge clk);
        chk(pd_out == 8'h5C, "R10 data holds last byte", pd_out, 8'h5C);
        chk(strobe_n == 1'b1, "R10 strobe idle when empty", strobe_n, 1);

        // R6: long counts near the 2 us period
        setup_len = 8'd60; pulse_len = 8'd80; hold_len = 8'd55;
        busy_in = 1'b1;
        repeat (3) @(negedge clk);
        push(8'h3D);
        push(8'h4E);
        busy_in = 1'b0;
        wait_idle();
        chk(setup_gap == 61, "R6 long setup gap", setup_gap, 61);
        chk(low_len == 81, "R6 long pulse width", low_len, 81);
        chk(hold_gap == 57, "R7 long hold gap", hold_gap, 57);

        // R6, R7: all counts zero
        setup_len = 8'd0; pulse_len = 8'd0; hold_len = 8'd0;
        busy_in = 1'b1;
        repeat (3) @(negedge clk);
        push(8'h71);
        push(8'h72);
        push(8'h73);
        busy_in = 1'b0;
        wait_idle();
        chk(setup_gap == 1, "R6 zero setup gap", setup_gap, 1);
        chk(low_len == 1, "R6 zero pulse width", low_len, 1);
        chk(hold_gap == 2, "R7 zero hold gap", hold_gap, 2);
        chk(pd_out == 8'h73, "R10 last zero-count byte held", pd_out, 8'h73);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule